// File: doc/BRIEF.md
# CAN Interrupt and Fault-Status Unit

This unit sits beside the protocol engine of a CAN controller and turns its single-cycle event pulses into latched interrupt sources and one interrupt request line. Four sources are kept: transmit, status change, overrun and transmit error. Each source has a pending flag and an enable bit. A flag latches whether or not its source is enabled. The request line is raised only by the flags whose enable bit is set.

The unit also derives the node's fault confinement state from the transmit and receive error counters. It reports error-passive and bus-off on separate outputs and in a control/status register. That register also holds a self-reception enable, which lets the node receive and store its own frames so that the communication path can be checked.

An early-transmit option moves the transmit event from frame completion to the moment arbitration is won. The status-change source follows the error state in run mode. In standby mode it follows a dominant-pulse detector instead.

Top module: `can_irq_status`

## Requirements
- R1: With the early-transmit bit clear, an `evt_tx_done` pulse sets pending bit 0 (transmit) at the next clock edge. If enable bit 0 is set, `irq` is high from that edge on.
- R2: With the early-transmit bit (enable register bit 4) set, `evt_arb_won` sets pending bit 0 and `evt_tx_done` has no effect on it.
- R3: In run mode (`run_mode`=1), any change of the registered error state (active, passive, bus-off) sets pending bit 1 (status change) in the same edge that updates the state. A counter change that leaves the state unchanged sets nothing.
- R4: In standby mode (`run_mode`=0), an `evt_dominant` pulse sets pending bit 1, and error state changes do not set it.
- R5: `evt_store_req` while `rx_buf_free` is 0 sets pending bit 2 (overrun). With a free buffer it sets nothing.
- R6: An `evt_tx_err` pulse sets pending bit 3 (transmit error).
- R7: `bus_off` goes high one edge after the 9-bit `tec` exceeds 255, and goes low one edge after `tec` is 255 or less.
- R8: `err_passive` is high one edge after `tec` or `rec` is 128 or more, but only while not bus-off. It is never high together with `bus_off`.
- R9: The control/status register reads 00h after reset. Bit 0 is the writable self-reception enable, driven on `self_rx_en`. Bit 1 mirrors error-passive and bit 2 mirrors bus-off, and writes to these two bits are ignored. Bits 7:3 read 0.
- R10: Writing `wr_sel`=2 clears every pending bit whose `wr_data` bit is 1. An event arriving in the same cycle keeps its bit set.
- R11: `irq` is the OR of the pending bits whose enable bits (enable register bits 3:0) are set. A disabled source still latches its pending bit.
- R12: The enable register (`wr_sel`=0) reads 00h after reset. Only bits 4:0 are writable, and bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_tx_done | input | 1 | Pulse: own frame transmitted successfully |
| evt_arb_won | input | 1 | Pulse: arbitration won by this node |
| evt_tx_err | input | 1 | Pulse: error detected while transmitting |
| evt_store_req | input | 1 | Pulse: accepted message to be stored |
| rx_buf_free | input | 1 | A receive buffer is available |
| evt_dominant | input | 1 | Pulse: dominant bit seen in standby |
| run_mode | input | 1 | 1 = run, 0 = standby |
| tec | input | 9 | Transmit error counter |
| rec | input | 8 | Receive error counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 enable reg, 1 control/status, 2 pending clear |
| wr_data | input | 8 | Write data |
| ie_rd | output | 8 | Enable register contents |
| cs_rd | output | 8 | Control/status register contents |
| pend_rd | output | 4 | Pending flags: 0 tx, 1 status, 2 overrun, 3 tx error |
| irq | output | 1 | Interrupt request |
| err_passive | output | 1 | Node is error passive |
| bus_off | output | 1 | Node is bus-off |
| self_rx_en | output | 1 | Self-reception enable |

## Verification
The bound checker watches on every cycle that each event pulse lands in its pending bit on the following edge. It also checks that the early-transmit selection steers the transmit source, that a dominant pulse in standby is caught, that bus-off follows the counter, and that error-passive and bus-off never coincide. Some behaviour can only be seen in the bench's directed scenarios: a counter change that leaves the error state alone must not raise a status event, standby must ignore state changes, a clear and an event in the same cycle must resolve in favour of the event, a disabled flag must latch while keeping the line low, and writes to the read-only status bits must be ignored.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 4;

    // pending / enable bit positions (software decodes these)
    localparam int SRC_TX    = 0;
    localparam int SRC_STAT  = 1;
    localparam int SRC_OVR   = 2;
    localparam int SRC_TXERR = 3;
    localparam int IE_EARLY  = 4;
    localparam logic [REG_W-1:0] IE_MASK = REG_W'((1 << (IE_EARLY + 1)) - 1);

    // control/status bit positions
    localparam int CS_SRX  = 0;
    localparam int CS_EPSV = 1;
    localparam int CS_BOFF = 2;

    typedef enum logic [1:0] {
        SEL_IE   = 2'd0,
        SEL_CS   = 2'd1,
        SEL_PEND = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } err_state_e;

    typedef struct packed {
        logic [REG_W-1:0] ie;
        logic             srx;
    } sw_regs_t;
endpackage

// File: rtl/can_irq_errstate.sv
module can_irq_errstate
    import can_irq_pkg::*;
#(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    output err_state_e       state_q_o,
    output logic             changed_o
);
    localparam logic [TEC_W-1:0] BOFF_LIM = TEC_W'((1 << (TEC_W - 1)) - 1);
    localparam logic [TEC_W-1:0] PASS_TEC = TEC_W'(PASSIVE_LIMIT);
    localparam logic [REC_W-1:0] PASS_REC = REC_W'(PASSIVE_LIMIT);

    typedef struct packed {
        err_state_e st;
    } es_t;

    es_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tec > BOFF_LIM)
            s_d.st = ST_BUSOFF;
        else if ((tec >= PASS_TEC) || (rec >= PASS_REC))
            s_d.st = ST_PASSIVE;
        else
            s_d.st = ST_ACTIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_ACTIVE};
        else        s_q <= s_d;
    end

    assign state_q_o = s_q.st;
    assign changed_o = (s_d.st != s_q.st);
endmodule

// File: rtl/can_irq_events.sv
module can_irq_events
    import can_irq_pkg::*;
(
    input  logic               evt_tx_done,
    input  logic               evt_arb_won,
    input  logic               evt_tx_err,
    input  logic               evt_store_req,
    input  logic               rx_buf_free,
    input  logic               evt_dominant,
    input  logic               run_mode,
    input  logic               early_tx,
    input  logic               state_chg,
    output logic [NUM_SRC-1:0] set_o
);
    always_comb begin
        set_o            = '0;
        set_o[SRC_TX]    = early_tx ? evt_arb_won : evt_tx_done;
        set_o[SRC_STAT]  = run_mode ? state_chg : evt_dominant;
        set_o[SRC_OVR]   = evt_store_req & ~rx_buf_free;
        set_o[SRC_TXERR] = evt_tx_err;
    end
endmodule

// File: rtl/can_irq_pend.sv
module can_irq_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } pd_t;

    pd_t          s_d, s_q;
    logic [N-1:0] nxt;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // a new event outranks a software clear in the same cycle
        assign nxt[g] = set_i[g] | (s_q.pend[g] & ~clr_i[g]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign irq_o  = |(s_q.pend & en_i);
endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_tx_done,
    input  logic               evt_arb_won,
    input  logic               evt_tx_err,
    input  logic               evt_store_req,
    input  logic               rx_buf_free,
    input  logic               evt_dominant,
    input  logic               run_mode,
    input  logic [TEC_W-1:0]   tec,
    input  logic [REC_W-1:0]   rec,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   ie_rd,
    output logic [REG_W-1:0]   cs_rd,
    output logic [NUM_SRC-1:0] pend_rd,
    output logic               irq,
    output logic               err_passive,
    output logic               bus_off,
    output logic               self_rx_en
);
    sw_regs_t           r_d, r_q;
    err_state_e         est;
    logic               est_chg;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;

    // software-visible registers
    always_comb begin
        r_d = r_q;
        if (wr_en && (wr_sel == SEL_IE))
            r_d.ie = wr_data & IE_MASK;
        if (wr_en && (wr_sel == SEL_CS))
            r_d.srx = wr_data[CS_SRX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clr_vec = (wr_en && (wr_sel == SEL_PEND)) ? wr_data[NUM_SRC-1:0] : '0;

    can_irq_errstate #(
        .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_LIMIT(PASSIVE_LIMIT)
    ) u_err (
        .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec),
        .state_q_o(est), .changed_o(est_chg)
    );

    can_irq_events u_evt (
        .evt_tx_done(evt_tx_done), .evt_arb_won(evt_arb_won),
        .evt_tx_err(evt_tx_err), .evt_store_req(evt_store_req),
        .rx_buf_free(rx_buf_free), .evt_dominant(evt_dominant),
        .run_mode(run_mode), .early_tx(r_q.ie[IE_EARLY]),
        .state_chg(est_chg), .set_o(set_vec)
    );

    can_irq_pend #(.N(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
        .en_i(r_q.ie[NUM_SRC-1:0]), .pend_o(pend_rd), .irq_o(irq)
    );

    assign err_passive = (est == ST_PASSIVE);
    assign bus_off     = (est == ST_BUSOFF);
    assign self_rx_en  = r_q.srx;
    assign ie_rd       = r_q.ie;

    always_comb begin
        cs_rd          = '0;
        cs_rd[CS_SRX]  = r_q.srx;
        cs_rd[CS_EPSV] = err_passive;
        cs_rd[CS_BOFF] = bus_off;
    end
endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_tx_done,
    input logic       evt_arb_won,
    input logic       evt_tx_err,
    input logic       evt_store_req,
    input logic       rx_buf_free,
    input logic       evt_dominant,
    input logic       run_mode,
    input logic       tec_hi,
    input logic [7:0] ie_rd,
    input logic [7:0] cs_rd,
    input logic [3:0] pend_rd,
    input logic       err_passive,
    input logic       bus_off
);
    AST_TX_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_rd[4] && evt_tx_done) |=> pend_rd[0]); // R1
    AST_TX_AT_ARB: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_rd[4] && evt_arb_won) |=> pend_rd[0]); // R2
    AST_DOM_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_mode && evt_dominant) |=> pend_rd[1]); // R4
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_store_req && !rx_buf_free) |=> pend_rd[2]); // R5
    AST_TX_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_err |=> pend_rd[3]); // R6
    AST_BOFF_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        tec_hi |=> bus_off); // R7
    AST_BOFF_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !tec_hi |=> !bus_off); // R7
    AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_off && err_passive)); // R8
    AST_CS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rd[2] == bus_off) && (cs_rd[1] == err_passive)); // R9
endmodule

bind can_irq_status can_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_tx_done(evt_tx_done),
    .evt_arb_won(evt_arb_won), .evt_tx_err(evt_tx_err),
    .evt_store_req(evt_store_req), .rx_buf_free(rx_buf_free),
    .evt_dominant(evt_dominant), .run_mode(run_mode),
    .tec_hi(tec[8]), .ie_rd(ie_rd), .cs_rd(cs_rd), .pend_rd(pend_rd),
    .err_passive(err_passive), .bus_off(bus_off)
);

// File: tb/sim_can_irq_status.sv
`timescale 1ns/1ps
module sim_can_irq_status;
    logic       clk = 0, rst_n = 0;
    logic       evt_tx_done = 0, evt_arb_won = 0, evt_tx_err = 0;
    logic       evt_store_req = 0, rx_buf_free = 1, evt_dominant = 0;
    logic       run_mode = 1;
    logic [8:0] tec = 0;
    logic [7:0] rec = 0;
    logic       wr_en = 0;
    logic [1:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] ie_rd, cs_rd;
    logic [3:0] pend_rd;
    logic       irq, err_passive, bus_off, self_rx_en;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    can_irq_status u0 (.*);

    // behavioural reference: state 0 active, 1 passive, 2 bus-off
    int m_ie = 0, m_srx = 0, m_st = 0;
    int m_pend[4] = '{0, 0, 0, 0};

    always @(posedge clk) begin
        int nst;
        int set[4];
        if (!rst_n) begin
            m_ie = 0; m_srx = 0; m_st = 0;
            foreach (m_pend[i]) m_pend[i] = 0;
        end else begin
            if (tec > 255) nst = 2;
            else if (tec >= 128 || rec >= 128) nst = 1;
            else nst = 0;
            set[0] = ((m_ie >> 4) & 1) ? int'(evt_arb_won) : int'(evt_tx_done);
            set[1] = run_mode ? int'(nst != m_st) : int'(evt_dominant);
            set[2] = int'(evt_store_req && !rx_buf_free);
            set[3] = int'(evt_tx_err);
            for (int i = 0; i < 4; i++) begin
                if (set[i] != 0) m_pend[i] = 1;
                else if (wr_en && wr_sel == 2 && wr_data[i]) m_pend[i] = 0;
            end
            if (wr_en && wr_sel == 0) m_ie = int'(wr_data) & 8'h1F;
            if (wr_en && wr_sel == 1) m_srx = int'(wr_data[0]);
            m_st = nst;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_pend_vec();
        int v = 0;
        for (int i = 0; i < 4; i++) v |= m_pend[i] << i;
        return v;
    endfunction

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk(ie_rd, m_ie, "R12 ie_rd");
            chk(cs_rd, m_srx | ((m_st == 1) << 1) | ((m_st == 2) << 2), "R9 cs_rd");
            chk(pend_rd, m_pend_vec(), "R10 pend_rd");
            chk(irq, int'((m_pend_vec() & m_ie & 15) != 0), "R11 irq");
            chk(err_passive, int'(m_st == 1), "R8 err_passive");
            chk(bus_off, int'(m_st == 2), "R7 bus_off");
            chk(self_rx_en, m_srx, "R9 self_rx_en");
        end
    end

    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(ie_rd, 0, "R12 reset");
        chk(cs_rd, 0, "R9 reset");
        chk(irq, 0, "R11 reset");

        wr(0, 8'hFF);
        chk(ie_rd, 8'h1F, "R12 writable bits");
        wr(2, 8'h0F);
        wr(0, 8'h01);

        evt_tx_done = 1; tick(); evt_tx_done = 0;
        chk(pend_rd[0], 1, "R1 tx flag");
        chk(irq, 1, "R1 irq");
        wr(2, 8'h01);
        chk(pend_rd, 0, "R10 cleared");
        chk(irq, 0, "R10 irq low");

        wr(0, 8'h11);
        evt_tx_done = 1; tick(); evt_tx_done = 0;
        chk(pend_rd[0], 0, "R2 done ignored");
        evt_arb_won = 1; tick(); evt_arb_won = 0;
        chk(pend_rd[0], 1, "R2 arb sets");
        wr(2, 8'h01);

        wr(0, 8'h00);
        evt_tx_err = 1; tick(); evt_tx_err = 0;
        chk(pend_rd[3], 1, "R6 txerr latched");
        chk(irq, 0, "R11 disabled");
        wr(0, 8'h08);
        chk(irq, 1, "R11 enabled");

        evt_tx_err = 1; wr(2, 8'h08); evt_tx_err = 0;
        chk(pend_rd[3], 1, "R10 event wins");
        wr(2, 8'h08);

        evt_store_req = 1; rx_buf_free = 1; tick();
        chk(pend_rd[2], 0, "R5 buffer free");
        rx_buf_free = 0; tick(); evt_store_req = 0; rx_buf_free = 1;
        chk(pend_rd[2], 1, "R5 overrun");
        wr(2, 8'h0F);

        run_mode = 1; wr(0, 8'h02);
        tec = 130; tick();
        chk(err_passive, 1, "R8 passive");
        chk(pend_rd[1], 1, "R3 change");
        wr(2, 8'h02);
        rec = 200; tec = 10; tick();
        chk(pend_rd[1], 0, "R3 no change");
        tec = 300; tick();
        chk(bus_off, 1, "R7 bus-off");
        chk(err_passive, 0, "R8 not with bus-off");
        chk(pend_rd[1], 1, "R3 to bus-off");
        wr(2, 8'h02);
        tec = 255; tick();
        chk(bus_off, 0, "R7 leave");
        chk(err_passive, 1, "R8 passive at 255");
        tec = 100; rec = 0; tick();
        chk(err_passive, 0, "R8 active");
        wr(2, 8'h02);

        run_mode = 0;
        tec = 150; tick();
        chk(pend_rd[1], 0, "R4 change ignored");
        evt_dominant = 1; tick(); evt_dominant = 0;
        chk(pend_rd[1], 1, "R4 dominant");
        chk(irq, 1, "R4 irq");

        wr(1, 8'hFF);
        chk(cs_rd, 8'h03, "R9 ro bits");
        chk(self_rx_en, 1, "R9 srx");
        wr(1, 8'h00);
        chk(self_rx_en, 0, "R9 srx off");
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule